// File: doc/BRIEF.md
# Master-Abort Read Response Handler

This block sits between the processor request path and the downstream expansion-bus masters (a general PCI bus, a graphics port bus, or more). Each downstream master state machine hands over one completion beat at a time. The beat carries a status (normal, master abort or special cycle), a direction flag, a last-beat flag and 64-bit read data. The block turns each beat into one response for the processor. A normal read forwards its data. An aborted read returns either an all-ones word or an explicit read-data-error flag, and a configuration input decides which. Writes and special cycles complete quietly.

Each bus owns a single-entry response slot. The slot is a small state machine with the states SL_IDLE, SL_FWD, SL_ONES, SL_RDERR and SL_ACK. An accepted beat moves the slot out of SL_IDLE along one of four transitions: *forward* to SL_FWD, *substitute* to SL_ONES, *flag* to SL_RDERR, or *acknowledge* to SL_ACK. The slot takes the *release* transition back to SL_IDLE when its response is handed over. A round-robin arbiter picks which occupied slot drives the single processor-side response channel. Once a response is on that channel, the arbiter keeps it there until it is taken.

Status encoding on `cmp_status`: 2'b00 normal completion, 2'b01 master abort, 2'b10 or 2'b11 special cycle (the low bit is ignored when the high bit is set).

Top module: `abort_rsp_unit`

## Requirements
- R1: After reset every `cmp_ready` bit is 1 and `rsp_valid` is 0.
- R2: A read beat (`cmp_write`=0) with status 2'b00 and no pending burst abort yields `rsp_write`=0, `rsp_err`=0 and `rsp_data` equal to the beat's data.
- R3: A read beat that counts as aborted, while `cfg_ones`=1, yields `rsp_err`=0, `rsp_write`=0 and `rsp_data` with all 64 bits set.
- R4: A read beat that counts as aborted, while `cfg_ones`=0, yields `rsp_err`=1, `rsp_write`=0 and `rsp_data` all zero.
- R5: `cfg_ones` is sampled on the clock edge where the beat is accepted. Later changes do not alter a response that is already waiting.
- R6: A beat whose status has bit 1 set (special cycle) yields `rsp_write`=1, `rsp_err`=0 and zero data, whatever the value of `cfg_ones`.
- R7: A write beat (`cmp_write`=1), whether normal or aborted, yields `rsp_write`=1, `rsp_err`=0 and zero data.
- R8: Within a read burst, once a beat with status 2'b01 and `cmp_last`=0 is accepted, every later read beat on that bus up to and including the next beat with `cmp_last`=1 counts as aborted, even if its status is 2'b00.
- R9: A bus holds at most one response. Its `cmp_ready` is 0 from the edge that accepts a beat until the edge where that response is handed over, and is 1 again right after that edge.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the next cycle still shows `rsp_valid`=1 with unchanged `rsp_bus`, `rsp_data`, `rsp_err`, `rsp_write` and `rsp_last`.
- R11: When not holding a stalled response, the channel serves the first occupied bus at or after a rotating pointer. The pointer starts at bus 0 and moves to the served bus plus one (wrapping) after each handover.
- R12: `rsp_bus` gives the index of the source bus, and `rsp_last` repeats the beat's `cmp_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ones | input | 1 | 1: aborted reads return all ones; 0: aborted reads return an error flag |
| cmp_valid | input | NUM_BUS | Per-bus completion beat present |
| cmp_ready | output | NUM_BUS | Per-bus slot can accept a beat |
| cmp_status | input | NUM_BUS x 2 | Per-bus completion status |
| cmp_write | input | NUM_BUS | Per-bus beat belongs to a write |
| cmp_last | input | NUM_BUS | Per-bus final beat of the transfer |
| cmp_data | input | NUM_BUS x DATA_W | Per-bus read data |
| rsp_valid | output | 1 | Processor response present |
| rsp_ready | input | 1 | Processor side takes the response |
| rsp_bus | output | clog2(NUM_BUS) | Source bus of the response |
| rsp_write | output | 1 | Response is a write/special acknowledge |
| rsp_err | output | 1 | Read-data-error indication |
| rsp_last | output | 1 | Final beat flag |
| rsp_data | output | DATA_W | Response data |

## Verification
The bench builds the block with NUM_BUS=3 and DATA_W=64. Three buses make the pointer wrap through a position that is not a power of two. They also allow stalls with two or three slots full at once, so the lock on a held response and the rotation order are both tested. The full 64-bit width means the all-ones and zero substitutions are compared against random data on every bit.

// File: rtl/abort_rsp_pkg.sv
package abort_rsp_pkg;

    // Slot states: one idle state plus one held state per response style.
    typedef enum logic [2:0] {
        SL_IDLE  = 3'd0,
        SL_FWD   = 3'd1,
        SL_ONES  = 3'd2,
        SL_RDERR = 3'd3,
        SL_ACK   = 3'd4
    } slot_state_e;

    // Picks the held state for an accepted beat.
    // status: 00 normal, 01 master abort, 1x special cycle.
    function automatic slot_state_e classify(
        input logic [1:0] status,
        input logic       is_write,
        input logic       burst_aborted,
        input logic       ones_mode
    );
        slot_state_e nxt;
        if (status[1] || is_write) begin
            nxt = SL_ACK;
        end else if (status[0] || burst_aborted) begin
            nxt = ones_mode ? SL_ONES : SL_RDERR;
        end else begin
            nxt = SL_FWD;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/abort_rsp_slot.sv
module abort_rsp_slot #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ones_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_status,
    input  logic              in_write,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic              pop,
    output logic              out_req,
    output logic              out_write,
    output logic              out_err,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    import abort_rsp_pkg::*;

    slot_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    logic              sticky_q, sticky_d;
    logic              take;

    assign take = in_valid && in_ready;

    // Next-state selection
    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            SL_IDLE: begin
                if (in_valid) begin
                    state_d = classify(in_status, in_write, sticky_q, ones_mode);
                end
            end
            SL_FWD, SL_ONES, SL_RDERR, SL_ACK: begin
                if (pop) begin
                    state_d = SL_IDLE;
                end
            end
            default: state_d = SL_IDLE;
        endcase
    end

    // Burst abort memory: set by an aborted non-final read beat, cleared by any final beat
    always_comb begin : sticky_next
        sticky_d = sticky_q;
        if (take) begin
            if (in_last) begin
                sticky_d = 1'b0;
            end else if (!in_write && (in_status == 2'b01)) begin
                sticky_d = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) begin
            state_q  <= SL_IDLE;
            sticky_q <= 1'b0;
            last_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            state_q  <= state_d;
            sticky_q <= sticky_d;
            if (take) begin
                last_q <= in_last;
                data_q <= in_data;
            end
        end
    end

    // Outputs decoded from the held state
    always_comb begin : outputs
        in_ready  = 1'b0;
        out_req   = 1'b1;
        out_write = 1'b0;
        out_err   = 1'b0;
        out_last  = last_q;
        out_data  = '0;
        unique case (state_q)
            SL_IDLE: begin
                in_ready = 1'b1;
                out_req  = 1'b0;
            end
            SL_FWD:   out_data  = data_q;
            SL_ONES:  out_data  = {DATA_W{1'b1}};
            SL_RDERR: out_err   = 1'b1;
            SL_ACK:   out_write = 1'b1;
            default: begin
                out_req = 1'b0;
            end
        endcase
    end

    // R9
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !in_ready);

    // R9
    pop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> in_ready);

    // R3
    ones_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_write && (in_status == 2'b01) && ones_mode)
        |=> (out_data == {DATA_W{1'b1}}) && !out_err && !out_write);

    // R4
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_write && (in_status == 2'b01) && !ones_mode)
        |=> out_err && (out_data == '0) && !out_write);

    // R6
    special_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_status[1]) |=> out_write && !out_err);

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_write) |=> out_write && !out_err);

endmodule

// File: rtl/abort_rsp_arb.sv
module abort_rsp_arb #(
    parameter  int NB = 2,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] req,
    input  logic          out_ready,
    output logic [NB-1:0] gnt,
    output logic [IW-1:0] sel,
    output logic          any
);
    logic [IW-1:0] ptr_q;
    logic          lock_q;
    logic [IW-1:0] lock_idx_q;
    logic [IW-1:0] pick;
    logic          found;
    logic [IW:0]   cand;

    // Rotating search from the pointer
    always_comb begin : search
        pick  = ptr_q;
        found = 1'b0;
        cand  = '0;
        for (int off = 0; off < NB; off++) begin
            cand = {1'b0, ptr_q} + (IW+1)'(off);
            if (cand >= (IW+1)'(NB)) begin
                cand = cand - (IW+1)'(NB);
            end
            if (!found && req[cand[IW-1:0]]) begin
                found = 1'b1;
                pick  = cand[IW-1:0];
            end
        end
    end

    always_comb begin : grant
        sel = lock_q ? lock_idx_q : pick;
        any = lock_q || found;
        gnt = '0;
        if (any) begin
            gnt[sel] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin : arb_reg
        if (!rst_n) begin
            ptr_q      <= '0;
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else if (any && out_ready) begin
            ptr_q  <= (sel == IW'(NB-1)) ? '0 : sel + 1'b1;
            lock_q <= 1'b0;
        end else if (any) begin
            lock_q     <= 1'b1;
            lock_idx_q <= sel;
        end
    end

    // R11
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R11
    gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((gnt & req) != '0));

endmodule

// File: rtl/abort_rsp_unit.sv
module abort_rsp_unit #(
    parameter  int NUM_BUS = 2,
    parameter  int DATA_W  = 64,
    localparam int BW      = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_ones,
    input  logic [NUM_BUS-1:0]              cmp_valid,
    output logic [NUM_BUS-1:0]              cmp_ready,
    input  logic [NUM_BUS-1:0][1:0]         cmp_status,
    input  logic [NUM_BUS-1:0]              cmp_write,
    input  logic [NUM_BUS-1:0]              cmp_last,
    input  logic [NUM_BUS-1:0][DATA_W-1:0]  cmp_data,
    output logic                            rsp_valid,
    input  logic                            rsp_ready,
    output logic [BW-1:0]                   rsp_bus,
    output logic                            rsp_write,
    output logic                            rsp_err,
    output logic                            rsp_last,
    output logic [DATA_W-1:0]               rsp_data
);
    logic [NUM_BUS-1:0]             slot_req;
    logic [NUM_BUS-1:0]             slot_write;
    logic [NUM_BUS-1:0]             slot_err;
    logic [NUM_BUS-1:0]             slot_last;
    logic [NUM_BUS-1:0][DATA_W-1:0] slot_data;
    logic [NUM_BUS-1:0]             gnt;
    logic [NUM_BUS-1:0]             pop;
    logic [BW-1:0]                  sel;
    logic                           any;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_slot
        assign pop[b] = gnt[b] && rsp_ready;

        abort_rsp_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ones_mode (cfg_ones),
            .in_valid  (cmp_valid[b]),
            .in_ready  (cmp_ready[b]),
            .in_status (cmp_status[b]),
            .in_write  (cmp_write[b]),
            .in_last   (cmp_last[b]),
            .in_data   (cmp_data[b]),
            .pop       (pop[b]),
            .out_req   (slot_req[b]),
            .out_write (slot_write[b]),
            .out_err   (slot_err[b]),
            .out_last  (slot_last[b]),
            .out_data  (slot_data[b])
        );
    end

    abort_rsp_arb #(.NB(NUM_BUS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (slot_req),
        .out_ready (rsp_ready),
        .gnt       (gnt),
        .sel       (sel),
        .any       (any)
    );

    always_comb begin : rsp_mux
        rsp_valid = any;
        rsp_bus   = sel;
        rsp_write = slot_write[sel] && any;
        rsp_err   = slot_err[sel] && any;
        rsp_last  = slot_last[sel] && any;
        rsp_data  = any ? slot_data[sel] : '0;
    end

    // R10
    held_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_bus) && $stable(rsp_data)
            && $stable(rsp_err) && $stable(rsp_write) && $stable(rsp_last));

    // R4
    err_means_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid && !rsp_write && (rsp_data == '0));

endmodule

// File: tb/abort_rsp_unit_test.sv
module abort_rsp_unit_test;
    localparam int NB = 3;
    localparam int DW = 64;
    localparam int BW = 2;
    localparam int RUN_CYCLES = 7000;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      cfg_ones = 1'b0;
    logic [NB-1:0]             cmp_valid = '0;
    logic [NB-1:0]             cmp_ready;
    logic [NB-1:0][1:0]        cmp_status = '0;
    logic [NB-1:0]             cmp_write = '0;
    logic [NB-1:0]             cmp_last = '0;
    logic [NB-1:0][DW-1:0]     cmp_data = '0;
    logic                      rsp_valid;
    logic                      rsp_ready = 1'b0;
    logic [BW-1:0]             rsp_bus;
    logic                      rsp_write;
    logic                      rsp_err;
    logic                      rsp_last;
    logic [DW-1:0]             rsp_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Behavioural model state
    bit          m_full   [NB];
    bit          m_write  [NB];
    bit          m_err    [NB];
    bit          m_last   [NB];
    bit [DW-1:0] m_data   [NB];
    bit          m_sticky [NB];
    string       m_tag    [NB];
    int          m_ptr = 0;
    bit          m_lock = 1'b0;
    int          m_lock_idx = 0;

    always #5 clk = ~clk;

    abort_rsp_unit #(.NUM_BUS(NB), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_ones(cfg_ones),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_status(cmp_status),
        .cmp_write(cmp_write), .cmp_last(cmp_last), .cmp_data(cmp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bus(rsp_bus),
        .rsp_write(rsp_write), .rsp_err(rsp_err), .rsp_last(rsp_last), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int rr_pick();
        for (int off = 0; off < NB; off++) begin
            int idx;
            idx = (m_ptr + off) % NB;
            if (m_full[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic new_beat(input int b, input int phase);
        int r;
        cmp_valid[b] = ($urandom_range(0, 9) < 6);
        r = $urandom_range(0, 9);
        cmp_status[b] = (r < 5) ? 2'b00 : (r < 8) ? 2'b01 : (r == 8) ? 2'b10 : 2'b11;
        cmp_write[b]  = ($urandom_range(0, 3) == 0);
        cmp_last[b]   = ($urandom_range(0, 4) < 2);
        cmp_data[b]   = {$urandom, $urandom};
        if (phase == 3) begin
            cmp_valid[b] = 1'b1;
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual %0d cycles expected below %0d", 200000, RUN_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stimulus
        bit acc [NB];
        int phase;
        for (int b = 0; b < NB; b++) begin
            m_full[b] = 0; m_sticky[b] = 0; m_tag[b] = "R2";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(cmp_ready == '1, "R1", "cmp_ready after reset", DW'(cmp_ready), DW'({NB{1'b1}}));
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", DW'(rsp_valid), '0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            int eb;
            bit any_full;
            @(negedge clk);
            // R9: one outstanding response per bus
            for (int b = 0; b < NB; b++) begin
                check(cmp_ready[b] == !m_full[b], "R9", $sformatf("cmp_ready[%0d]", b),
                      DW'(cmp_ready[b]), DW'(!m_full[b]));
            end
            any_full = 1'b0;
            for (int b = 0; b < NB; b++) any_full |= m_full[b];
            check(rsp_valid == any_full, "R10", "rsp_valid", DW'(rsp_valid), DW'(any_full));
            eb = m_lock ? m_lock_idx : rr_pick();
            if (rsp_valid && any_full) begin
                // R11 and R12: source bus order; R10 when held
                check(int'(rsp_bus) == eb, m_lock ? "R10" : "R11 R12", "rsp_bus",
                      DW'(rsp_bus), DW'(eb));
                check(rsp_write == m_write[eb], m_tag[eb], "rsp_write", DW'(rsp_write), DW'(m_write[eb]));
                check(rsp_err == m_err[eb], m_tag[eb], "rsp_err", DW'(rsp_err), DW'(m_err[eb]));
                check(rsp_data == m_data[eb], m_tag[eb], "rsp_data", rsp_data, m_data[eb]);
                check(rsp_last == m_last[eb], "R12", "rsp_last", DW'(rsp_last), DW'(m_last[eb]));
            end
            // Beats accepted at the coming edge
            for (int b = 0; b < NB; b++) acc[b] = cmp_valid[b] && !m_full[b];
            // Handover or lock at the coming edge
            if (any_full) begin
                if (rsp_ready) begin
                    m_full[eb] = 0;
                    m_ptr = (eb + 1) % NB;
                    m_lock = 0;
                end else begin
                    m_lock = 1;
                    m_lock_idx = eb;
                end
            end
            // Capture with cfg_ones as seen at the accepting edge (R5)
            for (int b = 0; b < NB; b++) begin
                if (acc[b]) begin
                    bit aborted;
                    m_full[b] = 1;
                    m_last[b] = cmp_last[b];
                    aborted = (cmp_status[b] == 2'b01) || m_sticky[b];
                    if (cmp_status[b][1]) begin
                        m_write[b] = 1; m_err[b] = 0; m_data[b] = '0; m_tag[b] = "R6";
                    end else if (cmp_write[b]) begin
                        m_write[b] = 1; m_err[b] = 0; m_data[b] = '0; m_tag[b] = "R7";
                    end else if (aborted) begin
                        m_write[b] = 0;
                        m_err[b]   = !cfg_ones;
                        m_data[b]  = cfg_ones ? {DW{1'b1}} : '0;
                        if (cmp_status[b] == 2'b00) m_tag[b] = "R8";
                        else m_tag[b] = cfg_ones ? "R3 R5" : "R4 R5";
                    end else begin
                        m_write[b] = 0; m_err[b] = 0; m_data[b] = cmp_data[b]; m_tag[b] = "R2";
                    end
                    if (cmp_last[b]) m_sticky[b] = 0;
                    else if (!cmp_write[b] && cmp_status[b] == 2'b01) m_sticky[b] = 1;
                end
            end
            @(posedge clk); #1;
            phase = (cyc < 2000) ? 0 : (cyc < 4000) ? 1 : (cyc < 4100) ? 3 : 2;
            for (int b = 0; b < NB; b++) begin
                if (acc[b] || !cmp_valid[b]) new_beat(b, phase);
            end
            cfg_ones  = (phase == 0) ? 1'b0 : (phase == 1) ? 1'b1 : 1'(($urandom_range(0, 1)));
            rsp_ready = (phase == 3) ? 1'b0 : ($urandom_range(0, 9) < 6);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule